// File: doc/BRIEF.md
# Two-Stage Periodic Loop Timer

This block paces a software control loop that polls rather than takes interrupts. Two down-counters are chained. A prescale counter decrements on every running clock. Each time it underflows, it reloads and steps a period counter. When the period counter underflows on such a step, it reloads and raises a sticky timeout flag. The flag therefore rises once every (prescale reload + 1) × (period reload + 1) running clocks. Any pair of reload values with the same product gives the same loop period.

Software first halts the timer and programs both reload registers. It then writes the control register with the load bit set and the halt bit clear. After that it polls the status register once per loop and clears the flag by writing a one to it. A small synchronous register port carries all of this, and read data is registered.

Top module: `loop_tmr`

## Requirements
- R1: After reset the halt bit is 1, both reload registers read 0, the timeout flag is 0 and read data is 0.
- R2: Register map (cfg_addr): 0 = control, 1 = prescale reload, 2 = period reload, 3 = status. Control bit 0 is halt. Control bit 1 is load: writing it as 1 copies both reload registers into the counters on that write edge, also while the counters are running, and the bit always reads back as 0.
- R3: Take a control write of value 2 (load, run) at edge W, with reloads P and Q. The flag is 0 after edge W+N-1 and 1 after edge W+N, where N = (P+1)(Q+1).
- R4: Reload pairs with equal products give the same period. P=4/Q=1249 and P=0/Q=6249 both give 6250 clocks, which is 16 kHz from 100 MHz.
- R5: Timeouts repeat every N clocks without any reload. The flag stays 1 until it is cleared.
- R6: While halt is 1, both counters hold their values. Clearing halt (control write of 0) at edge X resumes the count where it stopped, with no reload.
- R7: Writing status (address 3) with bit 0 = 1 clears the flag on that edge. Writing status with bit 0 = 0 has no effect.
- R8: If a clear and a timeout fall on the same edge, the flag ends up 1.
- R9: A write to a reload register while the timer runs does not change the count in progress. The new value takes effect at the counter's next underflow.
- R10: Reads return control bit 0 = halt, the reload values at addresses 1 and 2, and status bit 0 = flag. Read data appears one edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address |
| cfg_wdata | input | DATA_W | Write data |
| cfg_rdata | output | DATA_W | Registered read data |
| flag_o | output | 1 | Sticky timeout flag |

## Verification
The bench times each flag rise to the exact edge. An off-by-one in either counter's reload, or in the borrow from the prescaler, would move the rise by one clock or by a whole prescale interval. It places a clear exactly on a timeout edge; a design where the clear wins would lose a loop tick there. It halts mid-count and reloads mid-count, which exposes a design that restarts the count on resume or ignores a mid-run load. It also changes a reload register during a run; a design that reloads immediately would shorten the period already in progress. Both 6250-clock settings run end to end, so a period computed as a sum or skewed by an extra count shows up at once.

// File: rtl/loop_tmr_pkg.sv
package loop_tmr_pkg;
  localparam int ADDR_W        = 2;
  localparam int CTRL_HALT_BIT = 0;
  localparam int CTRL_LOAD_BIT = 1;
  localparam int STAT_FLAG_BIT = 0;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_PRE  = 2'd1,
    REG_PER  = 2'd2,
    REG_STAT = 2'd3
  } tmr_reg_e;
endpackage

// File: rtl/loop_tmr_regs.sv
module loop_tmr_regs
  import loop_tmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 16,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              flag,
  output logic              halt_q,
  output logic              load_p,
  output logic              clr_req,
  output logic [PRE_W-1:0]  pre_rld_q,
  output logic [PER_W-1:0]  per_rld_q,
  output logic [DATA_W-1:0] cfg_rdata
);
  logic wr_ctrl, wr_pre, wr_per, wr_stat;

  assign wr_ctrl = cfg_we && (cfg_addr == REG_CTRL);
  assign wr_pre  = cfg_we && (cfg_addr == REG_PRE);
  assign wr_per  = cfg_we && (cfg_addr == REG_PER);
  assign wr_stat = cfg_we && (cfg_addr == REG_STAT);

  assign load_p  = wr_ctrl && cfg_wdata[CTRL_LOAD_BIT];
  assign clr_req = wr_stat && cfg_wdata[STAT_FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_q    <= 1'b1;
      pre_rld_q <= '0;
      per_rld_q <= '0;
    end else begin
      if (wr_ctrl) halt_q    <= cfg_wdata[CTRL_HALT_BIT];
      if (wr_pre)  pre_rld_q <= cfg_wdata[PRE_W-1:0];
      if (wr_per)  per_rld_q <= cfg_wdata[PER_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_rdata <= '0;
    end else begin
      cfg_rdata <= '0;
      case (cfg_addr)
        REG_CTRL: cfg_rdata[CTRL_HALT_BIT] <= halt_q;
        REG_PRE:  cfg_rdata <= DATA_W'(pre_rld_q);
        REG_PER:  cfg_rdata <= DATA_W'(per_rld_q);
        REG_STAT: cfg_rdata[STAT_FLAG_BIT] <= flag;
        default:  cfg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/loop_tmr_cnt.sv
module loop_tmr_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] rld,
  output logic [W-1:0] cnt,
  output logic         wrap
);
  logic at_zero;

  assign at_zero = (cnt == '0);
  assign wrap    = step && !load && at_zero;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= rld;
    else if (step) cnt <= at_zero ? rld : cnt - W'(1);
  end
endmodule

// File: rtl/loop_tmr_flag.sv
module loop_tmr_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/loop_tmr.sv
module loop_tmr
  import loop_tmr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int PRE_W  = 16,
  parameter int PER_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic [DATA_W-1:0] cfg_rdata,
  output logic              flag_o
);
  logic             halt_q, load_p, clr_req;
  logic [PRE_W-1:0] pre_rld_q, pre_cnt;
  logic [PER_W-1:0] per_rld_q, per_cnt;
  logic             pre_wrap, timeout;

  loop_tmr_regs #(.DATA_W(DATA_W), .PRE_W(PRE_W), .PER_W(PER_W)) u_regs (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .flag(flag_o), .halt_q(halt_q), .load_p(load_p),
    .clr_req(clr_req), .pre_rld_q(pre_rld_q), .per_rld_q(per_rld_q),
    .cfg_rdata(cfg_rdata)
  );

  loop_tmr_cnt #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .load(load_p), .step(!halt_q),
    .rld(pre_rld_q), .cnt(pre_cnt), .wrap(pre_wrap)
  );

  loop_tmr_cnt #(.W(PER_W)) u_per (
    .clk(clk), .rst(rst), .load(load_p), .step(pre_wrap),
    .rld(per_rld_q), .cnt(per_cnt), .wrap(timeout)
  );

  loop_tmr_flag u_flag (
    .clk(clk), .rst(rst), .set(timeout), .clr(clr_req), .flag(flag_o)
  );
endmodule

// File: rtl/loop_tmr_chk.sv
module loop_tmr_chk #(
  parameter int PRE_W = 16,
  parameter int PER_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             halt_q,
  input logic             load_p,
  input logic             clr_req,
  input logic             timeout,
  input logic             flag_o,
  input logic [PRE_W-1:0] pre_rld_q,
  input logic [PER_W-1:0] per_rld_q,
  input logic [PRE_W-1:0] pre_cnt,
  input logic [PER_W-1:0] per_cnt
);
  p_reset_state_r1: assert property (@(posedge clk) rst |=> (!flag_o && halt_q));

  p_load_copies_r2: assert property (@(posedge clk) disable iff (rst)
    load_p |=> (pre_cnt == $past(pre_rld_q) && per_cnt == $past(per_rld_q)));

  p_rise_on_timeout_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_o) |-> $past(timeout));

  p_flag_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !clr_req) |=> flag_o);

  p_halt_freezes_r6: assert property (@(posedge clk) disable iff (rst)
    (halt_q && !load_p) |=> ($stable(pre_cnt) && $stable(per_cnt)));

  p_clear_works_r7: assert property (@(posedge clk) disable iff (rst)
    (clr_req && !timeout) |=> !flag_o);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
    timeout |=> flag_o);
endmodule

bind loop_tmr loop_tmr_chk #(.PRE_W(PRE_W), .PER_W(PER_W)) u_chk (
  .clk(clk), .rst(rst), .halt_q(halt_q), .load_p(load_p), .clr_req(clr_req),
  .timeout(timeout), .flag_o(flag_o), .pre_rld_q(pre_rld_q),
  .per_rld_q(per_rld_q), .pre_cnt(pre_cnt), .per_cnt(per_cnt)
);

// File: tb/sim_loop_tmr.sv
module sim_loop_tmr;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = 2'd0;
  logic [15:0] cfg_wdata = 16'd0;
  logic [15:0] cfg_rdata;
  logic        flag_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 0;

  typedef struct {
    int    at;
    bit    val;
    string req;
  } exp_t;
  exp_t sb[$];
  exp_t e;

  loop_tmr u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .flag_o(flag_o)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compares the flag against queued expectations at the scheduled cycle.
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].at <= cyc) begin
      e = sb.pop_front();
      n_chk++;
      if (e.at != cyc) begin
        n_bad++;
        $display("FAIL %s: expectation for cycle %0d missed (now %0d)", e.req, e.at, cyc);
      end else if (flag_o !== e.val) begin
        n_bad++;
        $display("FAIL %s: cycle %0d flag actual %0b expected %0b", e.req, cyc, flag_o, e.val);
      end
    end
  end

  task automatic push(input int at, input bit v, input string req);
    exp_t x;
    x.at = at; x.val = v; x.req = req;
    sb.push_back(x);
  endtask

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write lands on the next rising edge.
  task automatic wr(input logic [1:0] a, input int d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = 16'(d);
    @(posedge clk); #1;
    cfg_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [1:0] a, input int exp, input string req);
    cfg_we = 1'b0; cfg_addr = a;
    @(posedge clk); #1;
    chk(int'(cfg_rdata), exp, req);
    @(negedge clk);
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic run_period(input int p, input int q, input string req);
    int w, n;
    wr(2'd0, 1);
    wr(2'd3, 1);
    chk(int'(flag_o), 0, req);
    wr(2'd1, p);
    wr(2'd2, q);
    wr(2'd0, 2);
    w = cyc;
    n = (p + 1) * (q + 1);
    push(w + n - 1, 1'b0, req);
    push(w + n, 1'b1, req);
    wait_cyc(w + n + 1);
  endtask

  initial begin
    int w, n, x, l;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(int'(flag_o), 0, "R1");
    chk(int'(cfg_rdata), 0, "R1");
    rd_chk(2'd0, 1, "R1");
    rd_chk(2'd1, 0, "R1");
    rd_chk(2'd2, 0, "R1");
    rd_chk(2'd3, 0, "R1");

    // R3 / R10: basic period, N = 3*4 = 12
    wr(2'd1, 2);
    wr(2'd2, 3);
    rd_chk(2'd1, 2, "R10");
    rd_chk(2'd2, 3, "R10");
    wr(2'd0, 2);
    w = cyc; n = 12;
    rd_chk(2'd0, 0, "R2");
    push(w + n - 1, 1'b0, "R3");
    push(w + n, 1'b1, "R3");
    push(w + 2*n - 1, 1'b1, "R5");
    wait_cyc(w + n + 2);
    rd_chk(2'd3, 1, "R10");
    // R8: clear lands on the second timeout edge
    push(w + 2*n, 1'b1, "R8");
    push(w + 2*n + 1, 1'b1, "R8");
    wait_cyc(w + 2*n - 1);
    wr(2'd3, 1);
    wait_cyc(w + 2*n + 3);
    wr(2'd3, 0);
    chk(int'(flag_o), 1, "R7");
    wr(2'd3, 1);
    chk(int'(flag_o), 0, "R7");
    push(w + 3*n - 1, 1'b0, "R5");
    push(w + 3*n, 1'b1, "R5");
    wait_cyc(w + 3*n + 1);

    // R6: halt mid-count, N = 20
    wr(2'd0, 1);
    wr(2'd3, 1);
    wr(2'd1, 0);
    wr(2'd2, 19);
    wr(2'd0, 2);
    w = cyc;
    wait_cyc(w + 5);
    wr(2'd0, 1);
    push(w + 30, 1'b0, "R6");
    wait_cyc(w + 40);
    rd_chk(2'd0, 1, "R10");
    wr(2'd0, 0);
    x = cyc;
    push(x + 13, 1'b0, "R6");
    push(x + 14, 1'b1, "R6");
    wait_cyc(x + 15);

    // R4: equal products give equal periods
    run_period(0, 5, "R4");
    run_period(2, 1, "R4");
    run_period(4, 1249, "R4");
    run_period(0, 6249, "R4");

    // R9: reload change mid-run takes effect at next underflow
    wr(2'd0, 1);
    wr(2'd3, 1);
    wr(2'd1, 0);
    wr(2'd2, 9);
    wr(2'd0, 2);
    w = cyc;
    wait_cyc(w + 2);
    wr(2'd2, 4);
    push(w + 9, 1'b0, "R9");
    push(w + 10, 1'b1, "R9");
    wait_cyc(w + 11);
    wr(2'd3, 1);
    push(w + 14, 1'b0, "R9");
    push(w + 15, 1'b1, "R9");
    wait_cyc(w + 16);

    // R2: load while running restarts the count
    wr(2'd0, 1);
    wr(2'd3, 1);
    wr(2'd1, 1);
    wr(2'd2, 2);
    wr(2'd0, 2);
    w = cyc;
    push(w + 6, 1'b0, "R2");
    wait_cyc(w + 3);
    wr(2'd0, 2);
    l = cyc;
    push(l + 5, 1'b0, "R2");
    push(l + 6, 1'b1, "R2");
    wait_cyc(l + 8);

    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule